// File: doc/BRIEF.md
# Length-Prefixed Byte Packet Mover

This block moves framed packets from an inbound byte FIFO into a transmit FIFO. Every packet on the inbound side opens with a two-byte payload count, most significant byte first. The block takes in those two bytes and keeps them. It then copies exactly that many payload bytes to the transmit side and goes back to look for the next count. The count bytes themselves are never forwarded.

Every byte the block reads is taken through a valid/ready handshake. A count byte or a payload byte is consumed only in a cycle where the source actually offers it. The block never takes the arrival of one byte as proof that later bytes are present. When the transmit FIFO reports full, the payload move pauses: no byte is read from the source, and the remaining count is kept. Framing therefore stays aligned however slowly the source delivers, and no stray payload bytes are ever left behind to be taken for a following count.

Two status outputs are provided. `busy` marks a packet in progress. `packet_done` gives a single-cycle pulse as each packet completes.

Top module: `pkt_mover`

## Requirements
- R1: Source and destination data are 8 bits wide. The first count byte is the high byte and the second is the low byte. Neither count byte is ever pushed to the destination, and payload bytes reach `dst_data` unchanged and in order.
- R2: A count byte is consumed only in a cycle where `src_valid` is high. After the high byte has been taken, the block holds `src_ready` high and waits as long as needed for the low byte, consuming nothing else and pushing nothing.
- R3: After a count N is received, exactly N bytes are pushed to the destination. The next source byte is then treated as the high count byte of a new packet.
- R4: Each payload byte is pushed only in a cycle where `src_valid` and `src_ready` are both high. While the source is empty in mid-payload, nothing is pushed and the block stays mid-packet.
- R5: While `dst_full` is high during a payload, `dst_push` and `src_ready` are low and the remaining count is kept unchanged. The transfer resumes when `dst_full` falls.
- R6: A count of zero completes the packet in the cycle its low byte is consumed. No byte is pushed for that packet, and the next byte is a new count.
- R7: `packet_done` is high for exactly one cycle per packet. For a non-empty packet that cycle is the one in which the last payload byte is pushed.
- R8: `busy` is high from the cycle after the high count byte is consumed until the cycle after the packet completes, and low otherwise.
- R9: A synchronous active-high `rst` returns the block to waiting for a high count byte and clears the remaining count. `busy` is low after reset, and a packet started before reset is discarded.
- R10: A 1024-byte payload transfers completely under irregular source and destination flow. The packet that follows it is framed correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_data | input | 8 | Byte offered by the inbound FIFO |
| src_valid | input | 1 | Inbound FIFO holds a byte |
| src_ready | output | 1 | Block takes the offered byte this cycle |
| dst_data | output | 8 | Byte written to the transmit FIFO |
| dst_push | output | 1 | Write strobe for the transmit FIFO |
| dst_full | input | 1 | Transmit FIFO has no space |
| busy | output | 1 | A packet is in progress |
| packet_done | output | 1 | One-cycle pulse when a packet completes |

## Verification
The bound checker tests several rules on every cycle:
- no push while the destination is full or while a count byte is being taken;
- no push without a source handshake;
- the remaining count and the state are held on any stalled payload cycle;
- the count falls by one per push;
- the block waits in the low-count state while the source is empty;
- the block is idle after `packet_done` and after reset.

Only the bench scenarios can show framing across whole packets. They cover payload order and content, exact byte totals across sweeps of source-gap and destination-full patterns, zero-length packets, a 1024-byte payload followed by a short packet, and the discarding of a packet cut short by reset.

// File: rtl/pkt_mover_pkg.sv
package pkt_mover_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MV_LEN_MSB = 2'd0,
        MV_LEN_LSB = 2'd1,
        MV_BODY    = 2'd2
    } mover_state_e;

    typedef struct packed {
        logic ready;
        logic hdr_fire;
        logic body_fire;
        logic done;
    } mover_hs_t;

    function automatic logic in_header(input mover_state_e s);
        return (s == MV_LEN_MSB) || (s == MV_LEN_LSB);
    endfunction

endpackage

// File: rtl/pkt_mover_fsm.sv
module pkt_mover_fsm
    import pkt_mover_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         hdr_fire,
    input  logic         body_fire,
    input  logic         len_zero,
    input  logic         last_byte,
    output mover_state_e state
);
    mover_state_e state_d;

    always_comb begin
        state_d = state;
        case (state)
            MV_LEN_MSB: if (hdr_fire) state_d = MV_LEN_LSB;
            MV_LEN_LSB: if (hdr_fire) state_d = len_zero ? MV_LEN_MSB : MV_BODY;
            MV_BODY:    if (body_fire && last_byte) state_d = MV_LEN_MSB;
            default:    state_d = MV_LEN_MSB;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= MV_LEN_MSB;
        else     state <= state_d;
    end
endmodule

// File: rtl/pkt_mover_count.sv
module pkt_mover_count
    import pkt_mover_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    localparam int LEN_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  mover_state_e      state,
    input  logic [DATA_W-1:0] src_data,
    input  logic              hdr_fire,
    input  logic              body_fire,
    output logic [LEN_W-1:0]  remain,
    output logic              len_zero,
    output logic              last_byte
);
    logic [DATA_W-1:0] msb_q;
    logic [LEN_W-1:0]  len_full;

    assign len_full  = {msb_q, src_data};
    assign len_zero  = (len_full == '0);
    assign last_byte = (remain == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            msb_q  <= '0;
            remain <= '0;
        end else begin
            if (hdr_fire && state == MV_LEN_MSB) msb_q <= src_data;
            if (hdr_fire && state == MV_LEN_LSB) remain <= len_full;
            else if (body_fire)                  remain <= remain - LEN_W'(1);
        end
    end
endmodule

// File: rtl/pkt_mover_gate.sv
module pkt_mover_gate
    import pkt_mover_pkg::*;
(
    input  mover_state_e state,
    input  logic         src_valid,
    input  logic         dst_full,
    input  logic         len_zero,
    input  logic         last_byte,
    output mover_hs_t    hs
);
    logic hdr_phase;

    always_comb begin
        hdr_phase    = in_header(state);
        hs.ready     = hdr_phase || !dst_full;
        hs.hdr_fire  = hdr_phase && src_valid;
        hs.body_fire = (state == MV_BODY) && src_valid && !dst_full;
        hs.done      = (hs.body_fire && last_byte)
                     || (hs.hdr_fire && state == MV_LEN_LSB && len_zero);
    end
endmodule

// File: rtl/pkt_mover.sv
module pkt_mover
    import pkt_mover_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    localparam int LEN_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_push,
    input  logic              dst_full,
    output logic              busy,
    output logic              packet_done
);
    mover_state_e     state;
    mover_hs_t        hs;
    logic [LEN_W-1:0] remain;
    logic             len_zero;
    logic             last_byte;

    pkt_mover_gate u_gate (
        .state     (state),
        .src_valid (src_valid),
        .dst_full  (dst_full),
        .len_zero  (len_zero),
        .last_byte (last_byte),
        .hs        (hs)
    );

    pkt_mover_count #(.DATA_W(DATA_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .src_data  (src_data),
        .hdr_fire  (hs.hdr_fire),
        .body_fire (hs.body_fire),
        .remain    (remain),
        .len_zero  (len_zero),
        .last_byte (last_byte)
    );

    pkt_mover_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hdr_fire  (hs.hdr_fire),
        .body_fire (hs.body_fire),
        .len_zero  (len_zero),
        .last_byte (last_byte),
        .state     (state)
    );

    assign src_ready   = hs.ready;
    assign dst_push    = hs.body_fire;
    assign dst_data    = src_data;
    assign packet_done = hs.done;
    assign busy        = (state != MV_LEN_MSB);
endmodule

// File: rtl/pkt_mover_checker.sv
module pkt_mover_checker
    import pkt_mover_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input mover_state_e     state,
    input logic [LEN_W-1:0] remain,
    input logic             src_valid,
    input logic             src_ready,
    input logic             dst_full,
    input logic             dst_push,
    input logic             busy,
    input logic             packet_done
);
    assert_hdr_not_pushed_R1: assert property (@(posedge clk) disable iff (rst)
        (state != MV_BODY) |-> !dst_push);

    assert_wait_low_byte_R2: assert property (@(posedge clk) disable iff (rst)
        (state == MV_LEN_LSB && !src_valid) |=> (state == MV_LEN_LSB));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state == MV_BODY && dst_push) |=> (remain == $past(remain) - LEN_W'(1)));

    assert_push_has_data_R4: assert property (@(posedge clk) disable iff (rst)
        dst_push |-> (src_valid && src_ready));

    assert_no_push_full_R5: assert property (@(posedge clk) disable iff (rst)
        dst_full |-> !dst_push);

    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (state == MV_BODY && !dst_push) |=> (state == MV_BODY && $stable(remain)));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        packet_done |=> (!busy && !packet_done));

    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && remain == '0));
endmodule

bind pkt_mover pkt_mover_checker #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .remain      (remain),
    .src_valid   (src_valid),
    .src_ready   (src_ready),
    .dst_full    (dst_full),
    .dst_push    (dst_push),
    .busy        (busy),
    .packet_done (packet_done)
);

// File: tb/pkt_mover_bench.sv
module pkt_mover_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] src_data;
    logic       src_valid;
    logic       src_ready;
    logic [7:0] dst_data;
    logic       dst_push;
    logic       dst_full;
    logic       busy;
    logic       packet_done;

    always #2 clk = ~clk;

    pkt_mover u_pkt_mover (
        .clk(clk), .rst(rst), .src_data(src_data), .src_valid(src_valid),
        .src_ready(src_ready), .dst_data(dst_data), .dst_push(dst_push),
        .dst_full(dst_full), .busy(busy), .packet_done(packet_done)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] src_mem [0:4095];
    logic [7:0] exp_mem [0:4095];
    int src_n, src_idx, avail, exp_n, out_n, mism, done_n, full_viol, cyc;
    int vmode, fmode;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit vpat(input int m, input int c);
        case (m)
            0: return 1'b1;
            1: return (c % 3) != 0;
            2: return (c % 4) == 0;
            default: return ((c * 7) % 5) < 2;
        endcase
    endfunction

    function automatic bit fpat(input int m, input int c);
        case (m)
            0: return 1'b0;
            1: return (c % 5) == 1;
            2: return ((c / 8) % 2) == 1;
            default: return 1'b1;
        endcase
    endfunction

    task automatic clear_run();
        src_n = 0; src_idx = 0; avail = 0; exp_n = 0;
        out_n = 0; mism = 0; done_n = 0; full_viol = 0;
    endtask

    task automatic add_pkt(input int len, input int tag);
        logic [15:0] l16;
        l16 = 16'(len);
        src_mem[src_n] = l16[15:8]; src_n++;
        src_mem[src_n] = l16[7:0];  src_n++;
        for (int i = 0; i < len; i++) begin
            src_mem[src_n] = 8'((tag * 37 + i * 5 + 1) & 255);
            exp_mem[exp_n] = src_mem[src_n];
            src_n++;
            exp_n++;
        end
        avail = src_n;
    endtask

    task automatic step();
        @(negedge clk);
        src_valid = (src_idx < avail) && vpat(vmode, cyc);
        src_data  = src_valid ? src_mem[src_idx] : 8'h00;
        dst_full  = fpat(fmode, cyc);
        #1;
        if (dst_push) begin
            if (dst_full) full_viol++;
            if (out_n >= exp_n || dst_data !== exp_mem[out_n]) mism++;
            out_n++;
        end
        if (packet_done) done_n++;
        if (src_valid && src_ready) src_idx++;
        cyc++;
    endtask

    task automatic drain(input int limit);
        int k = 0;
        while ((src_idx < src_n || busy) && k < limit) begin
            step();
            k++;
        end
        step();
    endtask

    task automatic judge(input int npk, input string tag);
        chk(out_n == exp_n, "R3", {tag, " payload count"}, out_n, exp_n);
        chk(mism == 0, "R1", {tag, " payload content"}, mism, 0);
        chk(done_n == npk, "R7", {tag, " done pulses"}, done_n, npk);
        chk(full_viol == 0, "R5", {tag, " push while full"}, full_viol, 0);
        chk(busy == 1'b0, "R8", {tag, " idle at end"}, int'(busy), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int lens [7] = '{0, 1, 2, 5, 255, 256, 300};
        rst = 1'b1; src_valid = 1'b0; src_data = 8'h00; dst_full = 1'b0;
        vmode = 0; fmode = 0; cyc = 0;
        clear_run();
        repeat (3) step();
        // R9: reset state
        chk(busy == 1'b0, "R9", "busy in reset", int'(busy), 0);
        chk(dst_push == 1'b0, "R9", "push in reset", int'(dst_push), 0);
        chk(packet_done == 1'b0, "R9", "done in reset", int'(packet_done), 0);
        rst = 1'b0;

        // R3 R4 R5 R7: sweep of source-gap and destination-full patterns
        for (int vm = 0; vm < 4; vm++) begin
            for (int fm = 0; fm < 3; fm++) begin
                clear_run();
                vmode = vm; fmode = fm;
                for (int p = 0; p < 7; p++) add_pkt(lens[p], p + vm * 3 + fm);
                drain(20000);
                judge(7, $sformatf("sweep v%0d f%0d", vm, fm));
            end
        end

        // R10: 1024-byte payload, then a short packet
        clear_run(); vmode = 3; fmode = 1;
        add_pkt(1024, 50); add_pkt(3, 51);
        drain(20000);
        judge(2, "R10 long packet");
        chk(src_idx == src_n, "R10", "source fully consumed", src_idx, src_n);

        // R2: low count byte delayed, then a payload byte delayed (R4)
        clear_run(); vmode = 0; fmode = 0;
        add_pkt(4, 9);
        avail = 1;
        repeat (6) step();
        chk(src_idx == 1, "R2", "bytes taken with low byte absent", src_idx, 1);
        chk(busy == 1'b1, "R8", "busy after high byte", int'(busy), 1);
        chk(out_n == 0, "R2", "pushes during count", out_n, 0);
        avail = 3;
        repeat (6) step();
        chk(out_n == 1, "R4", "pushes with source empty", out_n, 1);
        chk(busy == 1'b1, "R4", "still mid-packet", int'(busy), 1);
        avail = src_n;
        drain(100);
        chk(out_n == 4 && mism == 0, "R2", "packet after delays", out_n, 4);
        chk(done_n == 1, "R7", "single done pulse", done_n, 1);

        // R6: zero-length packet then two-byte packet
        clear_run();
        add_pkt(0, 20); add_pkt(2, 21);
        step(); step();
        chk(done_n == 1 && out_n == 0, "R6", "zero length done on low byte", done_n, 1);
        drain(100);
        chk(out_n == 2 && mism == 0, "R6", "next packet after zero", out_n, 2);
        chk(done_n == 2, "R6", "done pulses", done_n, 2);

        // R5: destination full holds the count
        clear_run();
        add_pkt(6, 30);
        repeat (4) step();
        fmode = 3;
        repeat (10) step();
        chk(out_n == 2, "R5", "pushes while full", out_n, 2);
        chk(src_idx == 4, "R5", "source bytes taken while full", src_idx, 4);
        fmode = 0;
        drain(100);
        chk(out_n == 6 && mism == 0, "R5", "resume after full", out_n, 6);
        chk(done_n == 1, "R5", "done after resume", done_n, 1);

        // R9: reset mid-packet discards it
        clear_run();
        add_pkt(10, 40);
        avail = 5;
        repeat (8) step();
        chk(out_n == 3, "R9", "partial pushes before reset", out_n, 3);
        avail = src_idx;
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        chk(busy == 1'b0, "R9", "busy after reset", int'(busy), 0);
        chk(src_ready == 1'b1, "R9", "ready for count after reset", int'(src_ready), 1);
        clear_run();
        add_pkt(2, 41);
        drain(100);
        chk(out_n == 2 && mism == 0, "R9", "fresh packet after reset", out_n, 2);
        chk(done_n == 1, "R9", "done after reset", done_n, 1);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule